// File: doc/BRIEF.md
# Sized Add/Subtract/Compare Flag Unit

This unit performs integer addition, subtraction and comparison on two 32-bit source operands. It can work at an operation size of 8, 16 or 32 bits. Each operation produces a destination value and an updated 32-bit flags word. The flags word carries four condition flags: carry, signed overflow, sign and zero. Every flag is computed at the selected size.

At narrow sizes, the sized result is merged into the low bits of the old destination value, and the upper bits keep their old contents. Subtraction reports a borrow in the carry flag. The signed compare places the signed less-than result into the carry flag, so that unsigned condition tests can be used for signed ordering.

The caller supplies the operands, the old destination and the old flags word, together with an input strobe. One clock later the unit returns the merged destination, a write enable and the new flags word, with a valid strobe.

Top module: `sized_addsub_flags`

## Requirements
- R1: The flags word holds carry at bit 8, overflow at bit 9, sign at bit 10 and zero at bit 11. Every other bit of `flags_out` equals the same bit of `flags_old`.
- R2: `size` selects the width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. For 8-bit and 16-bit sizes, `dst_out` takes the sized result in its low 8 or 16 bits and keeps the upper bits of `dst_old`.
- R3: Add (op 0) writes all four flags. Carry is the carry out of the top sized bit. Overflow is set when both operand signs match and the result sign differs. Sign is the top sized result bit, and zero is set when the sized result is all zeros.
- R4: Subtract (op 2) writes all four flags. Carry is set when an unsigned borrow occurs. Overflow is set when the two operand signs differ and the result sign differs from the first operand.
- R5: Add-with-carry (op 1) adds the incoming carry flag (`flags_old` bit 8). Subtract-with-borrow (op 3) additionally subtracts it. Both ops write all four flags under the rules of R3 and R4.
- R6: Full compare (op 6) sets all four flags exactly as subtract would, and it leaves the destination unwritten.
- R7: Unsigned compare (op 4) writes only carry (borrow) and zero. Overflow and sign keep their old values.
- R8: Signed compare (op 5) writes zero, and it sets carry when the first operand is less than the second as signed numbers at the selected size. Overflow and sign keep their old values.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `dst_we` is high with it for ops 0 to 3 and low for every other op.
- R10: Op 7 is unused. It returns `dst_old` and `flags_old` unchanged, with `dst_we` low.
- R11: While reset is asserted, and afterwards until the first operation, `out_valid` and `dst_we` are low and `dst_out` and `flags_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | 0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 cmp unsigned, 5 cmp signed, 6 cmp full, 7 unused |
| size | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| dst_old | input | 32 | Previous destination value |
| flags_old | input | 32 | Previous flags word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dst_out | output | 32 | Merged destination value |
| dst_we | output | 1 | Destination write enable |
| flags_out | output | 32 | Updated flags word |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle strobe timing and the write-enable rule for each op,
- pass-through of the flag bits outside positions 8 to 11,
- preservation of the upper destination bits at narrow sizes,
- the flags that the two narrow compares leave untouched,
- the full hold of state on the unused op.

The arithmetic itself can only be shown by the bench scenarios. These compare every result against a behavioural model built on integer arithmetic. They cover the numeric value of carry, borrow, overflow and signed less-than at each size, and the effect of the incoming carry on add-with-carry and subtract-with-borrow.

// File: rtl/sized_addsub_flags.sv
module sized_addsub_flags #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] dst_old,
  input  logic [DW-1:0] flags_old,
  output logic          out_valid,
  output logic [DW-1:0] dst_out,
  output logic          dst_we,
  output logic [DW-1:0] flags_out
);
  localparam int CB = 8;
  localparam int OB = 9;
  localparam int SB = 10;
  localparam int ZB = 11;

  logic [DW-1:0] mask, b_eff, am, bm, res, dst_nx, flags_nx;
  logic [DW:0]   sum;
  logic          is_sub, cin, cout, sa, sb, sr, c_new, o_new, z_new, arith;

  assign is_sub = op[1] | op[2];
  assign arith  = ~op[2];
  assign b_eff  = is_sub ? ~src_b : src_b;

  always_comb begin
    case (op)
      3'd0:    cin = 1'b0;
      3'd1:    cin = flags_old[CB];
      3'd3:    cin = ~flags_old[CB];
      default: cin = 1'b1;
    endcase
  end

  always_comb begin
    case (size)
      2'd0:    mask = DW'({8{1'b1}});
      2'd1:    mask = DW'({16{1'b1}});
      default: mask = '1;
    endcase
  end

  assign am  = src_a & mask;
  assign bm  = b_eff & mask;
  assign sum = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, cin};
  assign res = sum[DW-1:0] & mask;

  always_comb begin
    case (size)
      2'd0:    begin cout = sum[8];  sa = src_a[7];  sb = b_eff[7];  sr = sum[7];  end
      2'd1:    begin cout = sum[16]; sa = src_a[15]; sb = b_eff[15]; sr = sum[15]; end
      default: begin cout = sum[DW]; sa = src_a[DW-1]; sb = b_eff[DW-1]; sr = sum[DW-1]; end
    endcase
  end

  assign c_new = is_sub ? ~cout : cout;
  assign o_new = (sa == sb) && (sr != sa);
  assign z_new = (res == '0);

  always_comb begin
    flags_nx = flags_old;
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd6: begin
        flags_nx[CB] = c_new;
        flags_nx[OB] = o_new;
        flags_nx[SB] = sr;
        flags_nx[ZB] = z_new;
      end
      3'd4: begin
        flags_nx[CB] = c_new;
        flags_nx[ZB] = z_new;
      end
      3'd5: begin
        flags_nx[CB] = o_new ^ sr;
        flags_nx[ZB] = z_new;
      end
      default: ;
    endcase
  end

  assign dst_nx = arith ? ((dst_old & ~mask) | res) : dst_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_we    <= 1'b0;
      dst_out   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      dst_we    <= in_valid & arith;
      if (in_valid) begin
        dst_out   <= dst_nx;
        flags_out <= flags_nx;
      end
    end
  end
endmodule

module sized_addsub_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [1:0]  size,
  input logic [31:0] dst_old,
  input logic [31:0] flags_old,
  input logic        out_valid,
  input logic [31:0] dst_out,
  input logic        dst_we,
  input logic [31:0] flags_out
);
  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !dst_we);
  assert_we_arith_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[2]) |=> dst_we);
  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2]) |=> !dst_we);
  assert_flag_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flags_out[7:0] == $past(flags_old[7:0])) &&
                 (flags_out[31:12] == $past(flags_old[31:12])));
  assert_merge8_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> dst_out[31:8] == $past(dst_old[31:8]));
  assert_merge16_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd1) |=> dst_out[31:16] == $past(dst_old[31:16]));
  assert_cmpu_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=> flags_out[10:9] == $past(flags_old[10:9]));
  assert_cmps_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd5) |=> flags_out[10:9] == $past(flags_old[10:9]));
  assert_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (flags_out == $past(flags_old)) &&
                                 (dst_out == $past(dst_old)) && !dst_we);
endmodule

bind sized_addsub_flags sized_addsub_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
  .dst_old(dst_old), .flags_old(flags_old), .out_valid(out_valid),
  .dst_out(dst_out), .dst_we(dst_we), .flags_out(flags_out)
);

// File: tb/sized_addsub_flags_tb.sv
module sized_addsub_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src_a = '0, src_b = '0, dst_old = '0, flags_old = '0;
  logic        out_valid, dst_we;
  logic [31:0] dst_out, flags_out;

  int total = 0;
  int bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sized_addsub_flags u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .flags_old(flags_old),
    .out_valid(out_valid), .dst_out(dst_out), .dst_we(dst_we), .flags_out(flags_out)
  );

  function automatic longint sx(longint v, int w);
    return v[w-1] ? v - (longint'(1) << w) : v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [2:0] o, logic [1:0] sz,
                     logic [31:0] a, logic [31:0] b, logic [31:0] d, logic [31:0] f);
    int w;
    longint m, ua, ub, ci, r, res, sa, sb, sr;
    logic c, ov, s, z, we;
    logic [31:0] ed, ef;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (longint'(1) << w) - 1;
    ua = longint'(a) & m;
    ub = longint'(b) & m;
    ci = longint'(f[8]);
    sa = sx(ua, w);
    sb = sx(ub, w);
    case (o)
      3'd0:    begin r = ua + ub;      sr = sa + sb;      end
      3'd1:    begin r = ua + ub + ci; sr = sa + sb + ci; end
      3'd3:    begin r = ua - ub - ci; sr = sa - sb - ci; end
      default: begin r = ua - ub;      sr = sa - sb;      end
    endcase
    res = r & m;
    c   = (o <= 3'd1) ? (r > m) : (r < 0);
    ov  = (sr > (longint'(1) << (w-1)) - 1) || (sr < -(longint'(1) << (w-1)));
    s   = res[w-1];
    z   = (res == 0);
    we  = (o <= 3'd3);
    ef  = f;
    if (o <= 3'd3 || o == 3'd6) begin ef[8] = c; ef[9] = ov; ef[10] = s; ef[11] = z; end
    else if (o == 3'd4) begin ef[8] = c; ef[11] = z; end
    else if (o == 3'd5) begin ef[8] = (sa < sb); ef[11] = z; end
    ed = we ? ((d & ~32'(m)) | 32'(res)) : d;

    op = o; size = sz; src_a = a; src_b = b; dst_old = d; flags_old = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid R9"}, {31'd0, out_valid}, 32'd1);
    check({tag, " dst_we R9"}, {31'd0, dst_we}, {31'd0, we});
    check({tag, " dst"}, dst_out, ed);
    check({tag, " flags"}, flags_out, ef);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 reset dst_we", {31'd0, dst_we}, 32'd0);
    check("R11 reset dst", dst_out, 32'd0);
    check("R11 reset flags", flags_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {31'd0, out_valid}, 32'd0);

    run("R3 add8 signed overflow", 3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 32'hDEAD_BEEF, 32'h0);
    run("R3 add8 carry zero", 3'd0, 2'd0, 32'h1111_11FF, 32'h2222_2201, 32'hCAFE_0000, 32'h0);
    run("R3 add32 carry", 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0);
    run("R2 add16 merge", 3'd0, 2'd1, 32'h0000_1234, 32'h0000_1111, 32'hDEAD_BEEF, 32'h0);
    run("R2 size3 is 32", 3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 32'h5555_5555, 32'h0);
    run("R1 passthrough", 3'd2, 2'd1, 32'h5, 32'h5, 32'h0, 32'hA5A5_F0FF);
    run("R4 sub8 borrow", 3'd2, 2'd0, 32'h0, 32'h1, 32'hFFFF_FF00, 32'h0);
    run("R4 sub32 overflow", 3'd2, 2'd2, 32'h8000_0000, 32'h1, 32'h0, 32'h0);
    run("R5 adc carry in", 3'd1, 2'd0, 32'h7F, 32'h0, 32'h0, 32'h0000_0100);
    run("R5 sbb borrow in", 3'd3, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0000_0100);
    run("R5 sbb no borrow in", 3'd3, 2'd1, 32'h10, 32'h10, 32'h0, 32'h0);
    run("R6 cmp equal", 3'd6, 2'd2, 32'h1234_5678, 32'h1234_5678, 32'hABCD_0123, 32'h0);
    run("R6 cmp overflow", 3'd6, 2'd0, 32'h80, 32'h01, 32'h77, 32'h0);
    run("R7 cmpu keeps o s", 3'd4, 2'd0, 32'h01, 32'h02, 32'h0, 32'h0000_0600);
    run("R7 cmpu clears", 3'd4, 2'd2, 32'h9, 32'h2, 32'h0, 32'h0000_0F00);
    run("R8 cmps less", 3'd5, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 32'h0);
    run("R8 cmps greater", 3'd5, 2'd1, 32'h0000_0005, 32'h0000_FFFD, 32'h0, 32'h0000_0600);
    run("R8 cmps ovf case", 3'd5, 2'd0, 32'h80, 32'h01, 32'h0, 32'h0);
    run("R10 unused op", 3'd7, 2'd0, 32'hFF, 32'h01, 32'h1357_9BDF, 32'hFFFF_FFFF);

    @(negedge clk);
    check("R9 idle no strobe", {31'd0, out_valid}, 32'd0);
    check("R9 idle no we", {31'd0, dst_we}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rd, rf;
      lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rd = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; rf = lcg;
      run("R3 R4 R5 R6 R7 R8 random", rf[2:0], rf[4:3], ra, rb, rd, rf);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule